// File: doc/BRIEF.md
# Block Edge Classifier for Visible Watermark Insertion

This unit decides, for each square image block of 8 by 8 pixels, whether the block carries strong detail (an edge block) or is smooth. A watermark embedder uses the verdict to pick fixed scaling and embedding factors for edge blocks. Pixels of one block arrive as a stream in raster order: left to right within a row, rows top to bottom. The block is sized by parameters. The pixel width defaults to 8 bits and the block side defaults to 8, which must be a power of two.

For every pixel the unit forms two first-order differences. The horizontal difference is taken against the pixel to its right, and the vertical difference against the pixel below it. Each difference is made positive with an adder-subtractor. If the subtraction borrows, the result is two's-complemented. The two magnitudes are added to give an edge amplitude, and the amplitudes of the block are summed. The sum is shifted right by the log2 of the pixel count to give the mean, and the mean is compared with a user threshold. A row buffer of one block width supplies the vertical neighbour. Because the right and lower neighbours arrive after the pixel itself, each neighbouring pair is scored when its later member arrives. Every pair contributes exactly once, so the block total does not change.

The pixel input is valid/ready. The unit never applies back-pressure: `in_ready` is high in every cycle after reset, and a pixel is taken on each clock edge where `in_valid` and `in_ready` are both high. Upstream may leave gaps by holding `in_valid` low, and gaps have no effect on the result. The result pins are plain: a one-cycle done pulse and a held edge flag.

Top module: `wm_edge_classifier`

## Requirements
- R1: While reset is high and in the first cycle after it, `blk_done` and `blk_edge` are 0. `in_ready` is 1 from the second cycle after reset onward.
- R2: The horizontal term of a pixel is |p(x,y) - p(x+1,y)|. At the right border of the block the neighbour is the pixel itself, so the term is 0.
- R3: The vertical term of a pixel is |p(x,y) - p(x,y+1)|. At the bottom border of the block the neighbour is the pixel itself, so the term is 0.
- R4: The block sum of all horizontal plus vertical terms is kept at full width (15 bits by default) without overflow. The largest sum, from a 0/255 checkerboard, is 28560.
- R5: `blk_edge` is 1 when the block sum shifted right by 6 (the mean over 64 pixels) is strictly greater than `edge_thr`. A mean equal to the threshold gives 0.
- R6: `blk_done` is high for exactly the one cycle that follows the clock edge accepting the 64th pixel of a block. `blk_edge` takes its new value in that same cycle.
- R7: `blk_edge` holds its value from one `blk_done` pulse until the next.
- R8: Cycles with `in_valid` low accept nothing and leave the result unchanged.
- R9: The sum restarts at zero for every block, so a block's verdict does not depend on earlier blocks.
- R10: `edge_thr` is used only in the cycle in which the 64th pixel is accepted. Its value during the other pixels of the block has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Pixel present on `in_pix` |
| in_ready | output | 1 | Unit accepts a pixel; high in every cycle after reset |
| in_pix | input | PIX_W | Pixel gray value, raster order within the block |
| edge_thr | input | PIX_W+1 | Mean amplitude threshold |
| blk_done | output | 1 | One-cycle pulse after the last pixel of a block |
| blk_edge | output | 1 | Edge verdict of the last finished block |

## Verification
The only results are `blk_done` and `blk_edge`. Both are registered, and both change on the clock edge that accepts the 64th pixel, so they are due one cycle after that pixel is driven. The bench drives every input on a falling edge and samples the two outputs on the falling edge that follows the accepting rising edge. It samples again one cycle later to check that the done pulse has ended, and it checks during idle cycles that the flag has not moved. Expected verdicts come from a bench model that scores right and lower neighbours directly. This is a different formulation from the design's left and upper scoring.

// File: rtl/wm_edge_pkg.sv
package wm_edge_pkg;
  localparam int unsigned DEF_PIX_W   = 8;
  localparam int unsigned DEF_BLK_DIM = 8;
endpackage

// File: rtl/wm_edge_absdiff.sv
module wm_edge_absdiff #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] mag
);
  logic [W:0] raw;
  // adder-subtractor: a + ~b + 1; carry-out 0 means the result is negative
  always_comb begin
    raw = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};
    if (raw[W]) mag = raw[W-1:0];
    else        mag = ~raw[W-1:0] + {{(W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/wm_edge_nbr_buf.sv
module wm_edge_nbr_buf #(
  parameter int unsigned PIX_W   = 8,
  parameter int unsigned BLK_DIM = 8,
  localparam int unsigned COL_W  = $clog2(BLK_DIM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [PIX_W-1:0] pix,
  input  logic [COL_W-1:0] col,
  input  logic [COL_W-1:0] row,
  output logic [PIX_W-1:0] left_pix,
  output logic [PIX_W-1:0] up_pix
);
  logic [PIX_W-1:0] prev_q;
  logic [PIX_W-1:0] line_q [BLK_DIM];

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      for (int i = 0; i < int'(BLK_DIM); i++) line_q[i] <= '0;
    end else if (take) begin
      prev_q      <= pix;
      line_q[col] <= pix;
    end
  end

  // a missing neighbour at the block border is the pixel itself
  always_comb begin
    left_pix = (col == '0) ? pix : prev_q;
    up_pix   = (row == '0) ? pix : line_q[col];
  end
endmodule

// File: rtl/wm_edge_accum.sv
module wm_edge_accum #(
  parameter int unsigned AMP_W = 9,
  parameter int unsigned CNT_W = 6,
  localparam int unsigned ACC_W = AMP_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             first,
  input  logic             last,
  input  logic [AMP_W-1:0] amp,
  input  logic [AMP_W-1:0] thr,
  output logic             done,
  output logic             edge_flag,
  output logic [ACC_W-1:0] sum
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum_next;
  logic [AMP_W-1:0] mean_next;

  always_comb begin
    sum_next  = (first ? '0 : acc_q) + {{CNT_W{1'b0}}, amp};
    mean_next = sum_next[ACC_W-1:CNT_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      done      <= 1'b0;
      edge_flag <= 1'b0;
    end else begin
      done <= take && last;
      if (take) acc_q <= sum_next;
      if (take && last) edge_flag <= (mean_next > thr);
    end
  end

  assign sum = acc_q;
endmodule

// File: rtl/wm_edge_classifier.sv
module wm_edge_classifier #(
  parameter int unsigned PIX_W   = wm_edge_pkg::DEF_PIX_W,
  parameter int unsigned BLK_DIM = wm_edge_pkg::DEF_BLK_DIM,
  localparam int unsigned COL_W  = $clog2(BLK_DIM),
  localparam int unsigned CNT_W  = 2 * COL_W,
  localparam int unsigned AMP_W  = PIX_W + 1,
  localparam int unsigned ACC_W  = AMP_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pix,
  input  logic [AMP_W-1:0] edge_thr,
  output logic             blk_done,
  output logic             blk_edge
);
  logic             ready_q;
  logic             take;
  logic [CNT_W-1:0] idx_q;
  logic             blk_first;
  logic             blk_last;
  logic [PIX_W-1:0] left_pix;
  logic [PIX_W-1:0] up_pix;
  logic [PIX_W-1:0] h_mag;
  logic [PIX_W-1:0] v_mag;
  logic [AMP_W-1:0] amp;
  logic [ACC_W-1:0] acc_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      ready_q <= 1'b1;
      if (take) idx_q <= idx_q + 1'b1;
    end
  end

  assign in_ready  = ready_q;
  assign take      = in_valid && ready_q;
  assign blk_first = (idx_q == '0);
  assign blk_last  = (idx_q == '1);

  wm_edge_nbr_buf #(.PIX_W(PIX_W), .BLK_DIM(BLK_DIM)) u_nbr (
    .clk(clk), .rst(rst), .take(take), .pix(in_pix),
    .col(idx_q[COL_W-1:0]), .row(idx_q[CNT_W-1:COL_W]),
    .left_pix(left_pix), .up_pix(up_pix)
  );

  wm_edge_absdiff #(.W(PIX_W)) u_hdiff (.a(in_pix), .b(left_pix), .mag(h_mag));
  wm_edge_absdiff #(.W(PIX_W)) u_vdiff (.a(in_pix), .b(up_pix),   .mag(v_mag));

  assign amp = {1'b0, h_mag} + {1'b0, v_mag};

  wm_edge_accum #(.AMP_W(AMP_W), .CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst(rst), .take(take), .first(blk_first), .last(blk_last),
    .amp(amp), .thr(edge_thr), .done(blk_done), .edge_flag(blk_edge),
    .sum(acc_sum)
  );
endmodule

// File: rtl/wm_edge_checker.sv
module wm_edge_checker #(
  parameter int unsigned ACC_W = 15
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             blk_done,
  input logic             blk_edge,
  input logic             blk_first,
  input logic [ACC_W-1:0] acc_sum
);
  // R1 / R8: the input is never stalled once out of reset
  a_r1_ready_rises: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> in_ready);
  a_r8_ready_holds: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> in_ready);
  // R6: a done pulse lasts one cycle and follows an accepted pixel
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    blk_done |=> !blk_done);
  a_r6_done_after_take: assert property (@(posedge clk) disable iff (rst)
    $rose(blk_done) |-> $past(in_valid && in_ready));
  // R7: verdict held between pulses
  a_r7_edge_held: assert property (@(posedge clk) disable iff (rst)
    !blk_done |-> $stable(blk_edge));
  // R4: running sum never wraps inside a block
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !blk_first) |=> acc_sum >= $past(acc_sum));
endmodule

bind wm_edge_classifier wm_edge_checker #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .blk_done(blk_done), .blk_edge(blk_edge), .blk_first(blk_first),
  .acc_sum(acc_sum)
);

// File: tb/wm_edge_classifier_tb.sv
module wm_edge_classifier_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_pix = '0;
  logic [8:0] edge_thr = '0;
  logic       blk_done;
  logic       blk_edge;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int img [8][8];

  always #5 clk = ~clk;

  wm_edge_classifier dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .edge_thr(edge_thr), .blk_done(blk_done),
    .blk_edge(blk_edge)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pat(input int mode, input int x, input int y);
    case (mode)
      0: return 77;
      1: return x * 10;
      2: return y * 20;
      3: return ((x + y) % 2) ? 255 : 0;
      default: return (x * 37 + y * 91 + x * y * 13) % 256;
    endcase
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // right/lower neighbour model; a border neighbour is the pixel itself
  function automatic int block_sum();
    int s = 0;
    for (int y = 0; y < 8; y++)
      for (int x = 0; x < 8; x++) begin
        s += iabs(img[y][x] - ((x < 7) ? img[y][x+1] : img[y][x]));
        s += iabs(img[y][x] - ((y < 7) ? img[y+1][x] : img[y][x]));
      end
    return s;
  endfunction

  // feed one block; gap>0 inserts idle cycles; early_thr is applied to pixels 0..62
  task automatic run_block(input string req, input int mode, input int thr,
                           input int gap, input int early_thr);
    int exp_edge;
    int prev_edge;
    for (int y = 0; y < 8; y++)
      for (int x = 0; x < 8; x++) img[y][x] = pat(mode, x, y);
    exp_edge = ((block_sum() >> 6) > thr) ? 1 : 0;
    prev_edge = blk_edge;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_pix   = 8'(img[i / 8][i % 8]);
      edge_thr = 9'((i == 63) ? thr : early_thr);
      @(posedge clk);
      if (gap > 0 && i < 63) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_pix   = 8'hA5;
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          check("R8 idle keeps flag", blk_edge, prev_edge);
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    edge_thr = 9'h1FF;
    check({req, " done due"}, blk_done, 1);
    check({req, " verdict"}, blk_edge, exp_edge);
    @(negedge clk);
    check("R6 done single", blk_done, 0);
    check("R7 flag held", blk_edge, exp_edge);
  endtask

  task automatic t_reset();
    check("R1 done in reset", blk_done, 0);
    check("R1 edge in reset", blk_edge, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 done after reset", blk_done, 0);
    @(negedge clk);
    check("R1 ready", in_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    run_block("R5 flat equal thr", 0, 0, 0, 0);           // sum 0, mean 0
    run_block("R2 hramp above", 1, 7, 0, 7);              // sum 560, mean 8
    run_block("R2 R5 hramp equal", 1, 8, 0, 8);
    run_block("R3 vramp above", 2, 16, 0, 16);            // sum 1120, mean 17
    run_block("R3 vramp equal", 2, 17, 0, 17);
    run_block("R4 checker max", 3, 445, 0, 445);          // sum 28560, mean 446
    run_block("R4 checker equal", 3, 446, 0, 446);
    run_block("R9 flat after checker", 0, 0, 0, 0);
    run_block("R8 hramp with gaps", 1, 7, 2, 7);
    run_block("R10 late thr low", 1, 7, 0, 511);
    run_block("R10 late thr high", 3, 500, 0, 0);
    run_block("R6 mixed block", 4, 60, 1, 60);
    run_block("R6 mixed block low thr", 4, 5, 0, 5);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 50000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule